// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This controller writes a contiguous block of bytes into an erased ultraviolet-erasable or one-time-programmable EPROM. It works through the addresses in ascending order and takes one byte per address from a valid/ready source. Before any pulse it reads the location once. It then applies fixed-width program pulses. After each pulse it reads the byte back and compares it with the target. It moves to the next address as soon as the byte matches, and it applies no extra pulse at that point. A byte that still does not match after the pulse budget ends the run with a failure.

When the last address has been written, the controller reads the whole block back twice and compares it with a stored copy of the targets. The first pass runs at an elevated read supply and the second at a low read supply. Done and fail report the result. On a failure the controller records the address and the phase that failed. The supply levels are digital selects for an external regulator, and the memory array sits outside the block.

The block holds at most 2^BUF_AW bytes per run, and the read access time ACC_CYC must be at least 2 cycles.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, and while idle, ce_n, pgm_n and oe_n are high, dq_oe and vpp_sel are low, vcc_sel is 0 (nominal), and done, fail and src_ready are low.
- R2: A start accepted in idle or after a finished run latches start_addr and end_addr. The controller then takes exactly one byte per address through the src_valid/src_ready handshake, in ascending order from start_addr to end_addr.
- R3: A program pulse drives pgm_n low for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 cycles. During the pulse ce_n is low, oe_n is high, dq_oe is 1, vpp_sel is 1 and vcc_sel is 1 (programming supply). addr_out and dq_out hold steady for the whole pulse.
- R4: After every pulse the byte is read back with oe_n low, pgm_n high and dq_oe 0. On a match the controller moves to the next address, so a byte that needs k pulses receives exactly k.
- R5: Each address is read once before the first pulse. If the read equals the target, no pulse is issued. If the target has a 1 in any bit where the read holds a 0, the run fails at that address with phase 1 and no pulse.
- R6: No address receives more than MAX_PULSES (25) pulses. A byte that still fails verify after pulse 25 ends the run with a failure at that address, phase 1 (program).
- R7: After the last address, every address from start to end is read and compared with its stored target. The first pass uses vcc_sel 2 (high read supply) and the second uses vcc_sel 3 (low read supply), both with vpp_sel 0. A mismatch fails with phase 2 or 3 respectively.
- R8: On a failure, done and fail are both 1, fail_addr holds the failing address and fail_phase holds the phase code. ce_n, pgm_n and oe_n go high, vpp_sel goes to 0 and vcc_sel goes to 0. These results stay in place until the next accepted start clears them.
- R9: When both read-back passes match, the run ends with done 1, fail 0 and fail_phase 0.
- R10: A start that arrives while a run is in progress has no effect on the addresses visited or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| start_addr | input | ADDR_W | First address of the block |
| end_addr | input | ADDR_W | Last address of the block |
| src_valid | input | 1 | Source byte available |
| src_data | input | DATA_W | Source byte |
| src_ready | output | 1 | Controller takes a byte this cycle if valid |
| ce_n | output | 1 | Chip enable, active low |
| pgm_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| addr_out | output | ADDR_W | Memory address |
| dq_out | output | DATA_W | Data driven toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DATA_W | Data read from the memory |
| vpp_sel | output | 1 | Select the high programming voltage |
| vcc_sel | output | 2 | Supply select: 0 nominal, 1 program, 2 high read, 3 low read |
| done | output | 1 | Run finished |
| fail | output | 1 | Run finished with a failure |
| fail_addr | output | ADDR_W | Address of the failure |
| fail_phase | output | 2 | 0 none, 1 program, 2 high-read pass, 3 low-read pass |

## Verification
Every control output is registered from the next state, so a strobe changes on the same clock edge as the state it belongs to. The bench counts pgm_n low time at falling clock edges and expects exactly PULSE_CYC samples per pulse. A start takes effect at the next rising edge, so the bench samples done low one falling edge later. Final results (done, fail, fail_addr, fail_phase) are polled at falling edges once done rises. The memory model counts each pulse on the rising edge of pgm_n, which gives exact per-address pulse counts to compare.

// File: rtl/eps_pkg.sv
package eps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRERD,
    ST_PULSE,
    ST_VFYRD,
    ST_CHKRD,
    ST_FIN
  } eps_state_t;

  typedef enum logic [1:0] {
    PH_NONE   = 2'd0,
    PH_PROG   = 2'd1,
    PH_CHK_HI = 2'd2,
    PH_CHK_LO = 2'd3
  } eps_phase_t;

  localparam logic [1:0] VCC_NOM  = 2'd0;
  localparam logic [1:0] VCC_PROG = 2'd1;
  localparam logic [1:0] VCC_HI   = 2'd2;
  localparam logic [1:0] VCC_LO   = 2'd3;

  // states in which the programming voltage is applied
  function automatic logic in_prog(input eps_state_t s);
    return (s == ST_PRERD) || (s == ST_PULSE) || (s == ST_VFYRD);
  endfunction

  // states that read the array
  function automatic logic in_read(input eps_state_t s);
    return (s == ST_PRERD) || (s == ST_VFYRD) || (s == ST_CHKRD);
  endfunction

endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/eps_pulse_ctr.sv
module eps_pulse_ctr #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                            cnt_q <= '0;
    else if (inc && (cnt_q != CW'(MAX_PULSES))) cnt_q <= cnt_q + CW'(1);
  end

  assign at_limit = (cnt_q >= CW'(MAX_PULSES));
endmodule

// File: rtl/eps_tgt_buf.sv
module eps_tgt_buf #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eps_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int ACC_CYC    = 4,
  parameter int MAX_PULSES = 25,
  parameter int BUF_AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              ce_n,
  output logic              pgm_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic              vpp_sel,
  output logic [1:0]        vcc_sel,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_phase
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int TMR_MAX   = (PULSE_CYC > ACC_CYC) ? PULSE_CYC : ACC_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] ACC_LD   = TMR_W'(ACC_CYC - 1);

  eps_state_t state_q, state_d;
  logic              chk_lo_q, chk_lo_d;
  logic [ADDR_W-1:0] cur_addr_q, start_q, end_q;
  logic [BUF_AW-1:0] off_q;
  logic [DATA_W-1:0] tgt_q;
  logic [DATA_W-1:0] buf_rdata;

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             at_limit, cnt_inc;
  logic             accept, begin_run, go_adv, go_fail, go_pass, rewind, step;
  eps_phase_t       fail_ph_d;
  logic             at_end;

  assign at_end = (cur_addr_q == end_q);

  eps_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  eps_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
    .clk(clk), .rst(rst), .clr(accept), .inc(cnt_inc), .at_limit(at_limit)
  );

  eps_tgt_buf #(.AW(BUF_AW), .DW(DATA_W)) u_buf (
    .clk(clk), .we(accept), .waddr(off_q), .wdata(src_data),
    .raddr(off_q), .rdata(buf_rdata)
  );

  // next-state decisions
  always_comb begin
    state_d   = state_q;
    chk_lo_d  = chk_lo_q;
    tmr_load  = 1'b0;
    tmr_val   = ACC_LD;
    cnt_inc   = 1'b0;
    accept    = 1'b0;
    begin_run = 1'b0;
    go_adv    = 1'b0;
    go_fail   = 1'b0;
    go_pass   = 1'b0;
    rewind    = 1'b0;
    step      = 1'b0;
    fail_ph_d = PH_PROG;

    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          begin_run = 1'b1;
          state_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (src_valid) begin
          accept   = 1'b1;
          state_d  = ST_PRERD;
          tmr_load = 1'b1;
        end
      end
      ST_PRERD: begin
        if (tmr_zero) begin
          if ((tgt_q & ~dq_in) != '0) begin
            go_fail = 1'b1;
          end else if (dq_in == tgt_q) begin
            go_adv = 1'b1;
          end else begin
            state_d  = ST_PULSE;
            tmr_load = 1'b1;
            tmr_val  = PULSE_LD;
          end
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          cnt_inc  = 1'b1;
          state_d  = ST_VFYRD;
          tmr_load = 1'b1;
        end
      end
      ST_VFYRD: begin
        if (tmr_zero) begin
          if (dq_in == tgt_q) begin
            go_adv = 1'b1;
          end else if (at_limit) begin
            go_fail = 1'b1;
          end else begin
            state_d  = ST_PULSE;
            tmr_load = 1'b1;
            tmr_val  = PULSE_LD;
          end
        end
      end
      ST_CHKRD: begin
        if (tmr_zero) begin
          if (dq_in != buf_rdata) begin
            go_fail   = 1'b1;
            fail_ph_d = chk_lo_q ? PH_CHK_LO : PH_CHK_HI;
          end else if (at_end) begin
            if (!chk_lo_q) begin
              chk_lo_d = 1'b1;
              rewind   = 1'b1;
              tmr_load = 1'b1;
            end else begin
              go_pass = 1'b1;
            end
          end else begin
            step     = 1'b1;
            tmr_load = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (go_adv) begin
      if (at_end) begin
        state_d  = ST_CHKRD;
        chk_lo_d = 1'b0;
        rewind   = 1'b1;
        tmr_load = 1'b1;
      end else begin
        state_d = ST_FETCH;
        step    = 1'b1;
      end
    end
    if (go_fail || go_pass) state_d = ST_FIN;
  end

  // datapath and result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      chk_lo_q   <= 1'b0;
      cur_addr_q <= '0;
      start_q    <= '0;
      end_q      <= '0;
      off_q      <= '0;
      tgt_q      <= '1;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_addr  <= '0;
      fail_phase <= PH_NONE;
    end else begin
      state_q  <= state_d;
      chk_lo_q <= chk_lo_d;
      if (begin_run) begin
        start_q    <= start_addr;
        end_q      <= end_addr;
        cur_addr_q <= start_addr;
        off_q      <= '0;
        done       <= 1'b0;
        fail       <= 1'b0;
        fail_phase <= PH_NONE;
      end
      if (accept) tgt_q <= src_data;
      if (rewind) begin
        cur_addr_q <= start_q;
        off_q      <= '0;
      end else if (step) begin
        cur_addr_q <= cur_addr_q + ADDR_W'(1);
        off_q      <= off_q + BUF_AW'(1);
      end
      if (go_fail) begin
        done       <= 1'b1;
        fail       <= 1'b1;
        fail_addr  <= cur_addr_q;
        fail_phase <= fail_ph_d;
      end
      if (go_pass) done <= 1'b1;
    end
  end

  // control outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n      <= 1'b1;
      pgm_n     <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      vpp_sel   <= 1'b0;
      vcc_sel   <= VCC_NOM;
      src_ready <= 1'b0;
    end else begin
      ce_n      <= !(in_prog(state_d) || (state_d == ST_CHKRD));
      pgm_n     <= (state_d != ST_PULSE);
      oe_n      <= !in_read(state_d);
      dq_oe     <= (state_d == ST_PULSE);
      vpp_sel   <= in_prog(state_d);
      src_ready <= (state_d == ST_FETCH);
      if (in_prog(state_d))         vcc_sel <= VCC_PROG;
      else if (state_d == ST_CHKRD) vcc_sel <= chk_lo_d ? VCC_LO : VCC_HI;
      else                          vcc_sel <= VCC_NOM;
    end
  end

  assign addr_out = cur_addr_q;
  assign dq_out   = tgt_q;

endmodule

// File: rtl/eps_seq_chk.sv
module eps_seq_chk #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 5000,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              src_ready,
  input logic              ce_n,
  input logic              pgm_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              vpp_sel,
  input logic [1:0]        vcc_sel,
  input logic              done,
  input logic              fail
);
  localparam int LW = $clog2(PULSE_CYC + 1) + 1;
  localparam int PW = $clog2(MAX_PULSES + 2) + 1;

  logic [LW-1:0] low_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          pgm_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      pulse_cnt <= '0;
      pgm_prev  <= 1'b1;
    end else begin
      pgm_prev <= pgm_n;
      if (!pgm_n) low_cnt <= low_cnt + LW'(1);
      else        low_cnt <= '0;
      if (src_ready)                pulse_cnt <= '0;
      else if (pgm_prev && !pgm_n)  pulse_cnt <= pulse_cnt + PW'(1);
    end
  end

  p_pulse_short_r3: assert property (@(posedge clk) disable iff (rst)
    !pgm_n |-> (low_cnt < LW'(PULSE_CYC)));

  p_pulse_full_r3: assert property (@(posedge clk) disable iff (rst)
    (pgm_n && !pgm_prev) |-> (low_cnt == LW'(PULSE_CYC)));

  p_pulse_cond_r3: assert property (@(posedge clk) disable iff (rst)
    !pgm_n |-> (!ce_n && oe_n && dq_oe && vpp_sel && vcc_sel == 2'd1));

  p_pulse_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!pgm_n && !pgm_prev) |-> ($stable(addr_out) && $stable(dq_out)));

  p_read_nodrive_r4: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!dq_oe && pgm_n));

  p_pulse_limit_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= PW'(MAX_PULSES));

  p_check_novpp_r7: assert property (@(posedge clk) disable iff (rst)
    vcc_sel[1] |-> !vpp_sel);

  p_fail_release_r8: assert property (@(posedge clk) disable iff (rst)
    fail |-> (done && ce_n && pgm_n && oe_n && !vpp_sel && vcc_sel == 2'd0));

endmodule

bind eprom_prog_seq eps_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst(rst), .src_ready(src_ready), .ce_n(ce_n), .pgm_n(pgm_n),
  .oe_n(oe_n), .addr_out(addr_out), .dq_out(dq_out), .dq_oe(dq_oe),
  .vpp_sel(vpp_sel), .vcc_sel(vcc_sel), .done(done), .fail(fail)
);

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 10;   // 100 kHz clock, 100 us pulse
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic          src_valid, src_ready;
  logic [7:0]    src_data;
  logic          ce_n, pgm_n, oe_n, dq_oe, vpp_sel, done, fail;
  logic [AW-1:0] addr_out, fail_addr;
  logic [7:0]    dq_out, dq_in;
  logic [1:0]    vcc_sel, fail_phase;

  int errs = 0, checks = 0, cyc = 0, lowc = 0;

  logic [7:0] mem [256];
  int         need [256];
  int         pcount [256];
  logic [7:0] weak_hi [256];
  logic [7:0] weak_lo [256];

  logic [7:0] feed [16];
  int         feed_n = 0, feed_idx = 0;
  logic       feed_clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(8), .CLK_HZ(100_000), .PULSE_US(100),
    .ACC_CYC(3), .MAX_PULSES(25), .BUF_AW(6)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .ce_n(ce_n), .pgm_n(pgm_n), .oe_n(oe_n), .addr_out(addr_out), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in), .vpp_sel(vpp_sel), .vcc_sel(vcc_sel),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_phase(fail_phase)
  );

  // byte source
  assign src_valid = (feed_idx < feed_n);
  assign src_data  = feed[feed_idx[3:0]];
  always @(posedge clk) begin
    if (feed_clr)                    feed_idx <= 0;
    else if (src_valid && src_ready) feed_idx <= feed_idx + 1;
  end

  // memory model: reads, with supply-dependent weak bits
  always_comb begin
    if (!ce_n && !oe_n)
      dq_in = mem[addr_out[7:0]] ^ ((vcc_sel == 2'd2) ? weak_hi[addr_out[7:0]] :
                                    (vcc_sel == 2'd3) ? weak_lo[addr_out[7:0]] : 8'h00);
    else
      dq_in = 8'hFF;
  end

  // memory model: a pulse lands when pgm_n rises
  always @(posedge pgm_n) begin
    if (!ce_n && vpp_sel && vcc_sel == 2'd1) begin
      pcount[addr_out[7:0]] = pcount[addr_out[7:0]] + 1;
      if (pcount[addr_out[7:0]] >= need[addr_out[7:0]])
        mem[addr_out[7:0]] = mem[addr_out[7:0]] & dq_out;
      checks++;
      if (lowc != PULSE_CYC) begin
        errs++;
        $display("FAIL R3 pulse width act=%0d exp=%0d", lowc, PULSE_CYC);
      end
    end
    lowc = 0;
  end

  always @(negedge clk) begin
    if (!pgm_n) lowc = lowc + 1;
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic erase();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; need[i] = 1; pcount[i] = 0; weak_hi[i] = 8'h00; weak_lo[i] = 8'h00;
    end
  endtask

  task automatic kick(input logic [AW-1:0] s, input logic [AW-1:0] e);
    @(negedge clk);
    start_addr = s; end_addr = e; start = 1'b1; feed_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; feed_clr = 1'b0;
    chk(done == 1'b0 && fail == 1'b0, "R8 cleared by start", {done, fail}, 0);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done == 1'b1, "R2 run completes", done, 1);
  endtask

  task automatic chk_idle_strobes(input string req);
    chk(ce_n && pgm_n && oe_n && !vpp_sel && vcc_sel == 2'd0 && !dq_oe, req,
        {ce_n, pgm_n, oe_n, vpp_sel, vcc_sel, dq_oe}, 7'b1110000);
  endtask

  task automatic t_reset();
    chk_idle_strobes("R1 strobes after reset");
    chk(!done && !fail && !src_ready, "R1 flags after reset", {done, fail, src_ready}, 0);
  endtask

  task automatic t_normal();
    erase();
    feed[0] = 8'hA5; feed[1] = 8'hFF; feed[2] = 8'h3C; feed[3] = 8'h00; feed_n = 4;
    need[8'h10] = 1; need[8'h12] = 3; need[8'h13] = 25;
    kick(18'h3FF10, 18'h3FF13);
    wait_done();
    chk(!fail && fail_phase == 2'd0, "R9 pass result", {fail, fail_phase}, 0);
    chk(pcount[8'h10] == 1, "R4 one pulse then advance", pcount[8'h10], 1);
    chk(pcount[8'h11] == 0, "R5 matching byte gets no pulse", pcount[8'h11], 0);
    chk(pcount[8'h12] == 3, "R4 three pulses", pcount[8'h12], 3);
    chk(pcount[8'h13] == 25, "R6 25 pulses still pass", pcount[8'h13], 25);
    chk(mem[8'h10] == 8'hA5 && mem[8'h12] == 8'h3C && mem[8'h13] == 8'h00,
        "R2 bytes land in order", {mem[8'h10], mem[8'h12], mem[8'h13]}, 24'hA53C00);
    chk(feed_idx == 4, "R2 one byte per address", feed_idx, 4);
    chk_idle_strobes("R9 strobes idle after pass");
  endtask

  task automatic t_limit();
    erase();
    feed[0] = 8'h12; feed[1] = 8'h34; feed[2] = 8'h56; feed_n = 3;
    need[8'h21] = 26;
    kick(18'h00020, 18'h00022);
    wait_done();
    chk(fail && fail_phase == 2'd1, "R6 fail in program phase", {fail, fail_phase}, 3'b101);
    chk(fail_addr == 18'h00021, "R6 fail address", fail_addr, 18'h21);
    chk(pcount[8'h21] == 25, "R6 pulse count capped", pcount[8'h21], 25);
    chk(pcount[8'h22] == 0 && mem[8'h22] == 8'hFF, "R8 stops after fail", pcount[8'h22], 0);
    chk_idle_strobes("R8 strobes released on fail");
    repeat (5) @(negedge clk);
    chk(done && fail && fail_addr == 18'h00021, "R8 result held", {done, fail}, 3);
  endtask

  task automatic t_zero_bit();
    erase();
    mem[8'h30] = 8'h0F;
    feed[0] = 8'h3F; feed_n = 1;
    kick(18'h00030, 18'h00030);
    wait_done();
    chk(fail && fail_phase == 2'd1 && fail_addr == 18'h00030, "R5 zero-to-one fails",
        {fail, fail_phase}, 3'b101);
    chk(pcount[8'h30] == 0, "R5 no pulse on zero-to-one", pcount[8'h30], 0);
  endtask

  task automatic t_check_hi();
    erase();
    feed[0] = 8'h11; feed[1] = 8'h22; feed[2] = 8'h33; feed_n = 3;
    weak_hi[8'h41] = 8'h01;
    kick(18'h00040, 18'h00042);
    wait_done();
    chk(fail && fail_phase == 2'd2, "R7 high-read pass fail", {fail, fail_phase}, 3'b110);
    chk(fail_addr == 18'h00041, "R7 high-read fail address", fail_addr, 18'h41);
    chk(mem[8'h42] == 8'h33, "R7 all bytes written before checks", mem[8'h42], 8'h33);
  endtask

  task automatic t_check_lo();
    erase();
    feed[0] = 8'h01; feed[1] = 8'h02; feed[2] = 8'h03; feed_n = 3;
    weak_lo[8'h52] = 8'h80;
    kick(18'h00050, 18'h00052);
    wait_done();
    chk(fail && fail_phase == 2'd3, "R7 low-read pass fail", {fail, fail_phase}, 3'b111);
    chk(fail_addr == 18'h00052, "R7 low pass reaches last address", fail_addr, 18'h52);
  endtask

  task automatic t_start_busy();
    erase();
    feed[0] = 8'h5A; feed[1] = 8'hC3; feed_n = 2;
    need[8'h60] = 4; need[8'h61] = 4;
    kick(18'h00060, 18'h00061);
    repeat (3) @(negedge clk);
    start_addr = 18'h00070; end_addr = 18'h00070; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R10 busy start does not end run", done, 0);
    wait_done();
    chk(!fail, "R10 run result unaffected", fail, 0);
    chk(mem[8'h60] == 8'h5A && mem[8'h61] == 8'hC3, "R10 original range written",
        {mem[8'h60], mem[8'h61]}, 16'h5AC3);
    chk(pcount[8'h70] == 0 && pcount[8'h60] == 4, "R10 second range untouched",
        pcount[8'h70], 0);
  endtask

  initial begin
    erase();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_limit();
    t_zero_bit();
    t_check_hi();
    t_check_lo();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule